// File: doc/BRIEF.md
# Serial Port Controller with FIFO-Level Interrupts

This block is an asynchronous serial transmitter and receiver behind a small 32-bit register port. Software sets the character format, the bit rate and two FIFO-level thresholds. It then pushes bytes into a 64-entry transmit queue and pops received bytes from a 64-entry receive queue. A single level interrupt tells software that the transmit queue has drained below its threshold or that the receive queue has filled to its threshold.

The bit clock is derived from the 24 MHz core clock: one bit lasts `3 * (divisor + 1)` core cycles. The programmed divisor applies only when both baud-source bits are set. Otherwise the parameter `DEF_DIV` applies. By default, hardware flow control is active: the transmitter waits for clear-to-send, and ready-to-send drops while the receive queue is full. Setting the two-wire bit removes both. A ready-to-send suppress bit lets software hold the line off while the port is idle.

Register word addresses are: 0 transmit data (write), 1 receive data (read), 2 control, 3 status, 4 thresholds, 5 baud.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset, txd and rts are 1 and irq is 0. The status word (address 3) reads rxEmpty (bit 0) = 1, txFull (bit 1) = 0, and both counts are 0.
- R2: A transmitted character is one start bit at 0, then the data bits LSB first, then an optional parity bit, then one or two stop bits at 1. The data length is 5 + control[1:0]. Parity is set by control[4:3]: 0 = none, 1 = even, 2 = odd. control[2] selects two stop bits.
- R3: Each bit lasts 3*(baud[11:0]+1) clock cycles when baud bits 23 and 24 are both set. Otherwise it lasts 3*(DEF_DIV+1) clock cycles.
- R4: Writing address 0 pushes wdata[7:0] into a 64-entry transmit FIFO. A write while the FIFO is full is dropped. Status bit 1 is txFull, and status[22:16] is the transmit count.
- R5: Received bytes enter a 64-entry FIFO. Reading address 1 returns the oldest byte in [7:0] and pops it. A read while the FIFO is empty returns 0 and pops nothing. Status[14:8] is the receive count.
- R6: A parity mismatch sets sticky status bit 3. A 0 in the first stop bit sets sticky status bit 2. A control write with bit 13 set clears both.
- R7: A control write with bit 11 set empties the receive FIFO. A control write with bit 12 set empties the transmit FIFO.
- R8: With control bit 5 (two-wire) at 0, no new character starts while cts is 0. With bit 5 at 1, cts is ignored.
- R9: rts is 0 whenever control bit 6 is set, and also when bit 5 is 0 and the receive FIFO holds 64 bytes. Otherwise rts is 1.
- R10: irq is high when control bit 9 is set and the transmit count is below thresholds[7:0]. It is also high when control bit 10 is set and the receive count is at least thresholds[15:8].
- R11: While control bit 7 is 0, queued transmit bytes stay queued and txd stays at 1. While control bit 8 is 0, activity on rxd queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops at address 1) |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear-to-send from the far end, active high |
| rts | output | 1 | Ready-to-send to the far end, active high |
| irq | output | 1 | FIFO-level interrupt |

## Verification
The assertions assume that software changes the format or baud registers only while no character is in flight in either direction. They also assume that the far end sends characters at the same bit period and format that the block is programmed for. The stimulus enforces both conditions: each reconfiguration waits until the scoreboard queue has drained and the last stop bit has passed, and the serial driver uses the same bit period that the bench programmed. Both FIFO-full cases are forced deliberately. The transmit FIFO is filled with the transmitter disabled, and the receive FIFO is filled while the bench ignores rts.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int DIV_W      = 12;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int BC_W       = DIV_W + 2;
  localparam int FRM_W      = 12;

  localparam logic [2:0] A_TXDATA = 3'd0;
  localparam logic [2:0] A_RXDATA = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_STAT   = 3'd3;
  localparam logic [2:0] A_THRESH = 3'd4;
  localparam logic [2:0] A_BAUD   = 3'd5;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef struct packed {
    logic [1:0]      lenSel;
    logic            twoStop;
    logic [1:0]      parSel;
    logic            twoWire;
    logic            rtsInv;
    logic            txEn;
    logic            rxEn;
    logic            txIrqEn;
    logic            rxIrqEn;
    logic [BC_W-1:0] bitCycles;
    logic [7:0]      txThresh;
    logic [7:0]      rxThresh;
  } cfg_t;

  typedef struct packed {
    logic       pushTx;
    logic       popRx;
    logic       clrTx;
    logic       clrRx;
    logic       clrErr;
    logic [7:0] wrByte;
  } strobe_t;

  typedef struct packed {
    logic             rxEmpty;
    logic             rxFull;
    logic             txFull;
    logic             frameErr;
    logic             parErr;
    logic [CNT_W-1:0] rxCount;
    logic [CNT_W-1:0] txCount;
    logic [7:0]       rxHead;
  } status_t;
endpackage

// File: rtl/sp_fifo.sv
`timescale 1ns/1ps
module sp_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           din,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (doPush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (doPush) wp <= wp + PW'(1);
      if (doPop)  rp <= rp + PW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R4: occupancy never passes the depth
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sp_ctrl.sv
`timescale 1ns/1ps
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int DEF_DIV = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  status_t       st,
  output cfg_t          cfg,
  output strobe_t       stb
);
  logic [10:0]      ctrlR;
  logic [15:0]      threshR;
  logic [DIV_W-1:0] divR;
  logic             useXtal, useNew;
  logic [DIV_W-1:0] effDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR <= '0; threshR <= '0; divR <= '0; useXtal <= 1'b0; useNew <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        A_CTRL:   ctrlR <= wdata[10:0];
        A_THRESH: threshR <= wdata[15:0];
        A_BAUD: begin
          divR <= wdata[DIV_W-1:0]; useXtal <= wdata[23]; useNew <= wdata[24];
        end
        default: ;
      endcase
    end
  end

  assign effDiv = (useXtal && useNew) ? divR : DIV_W'(DEF_DIV);

  always_comb begin
    cfg.lenSel    = ctrlR[1:0];
    cfg.twoStop   = ctrlR[2];
    cfg.parSel    = ctrlR[4:3];
    cfg.twoWire   = ctrlR[5];
    cfg.rtsInv    = ctrlR[6];
    cfg.txEn      = ctrlR[7];
    cfg.rxEn      = ctrlR[8];
    cfg.txIrqEn   = ctrlR[9];
    cfg.rxIrqEn   = ctrlR[10];
    cfg.bitCycles = ({2'b00, effDiv} + BC_W'(1)) * BC_W'(3);
    cfg.txThresh  = threshR[7:0];
    cfg.rxThresh  = threshR[15:8];
  end

  always_comb begin
    stb.pushTx = wrEn && (addr == A_TXDATA);
    stb.wrByte = wdata[7:0];
    stb.popRx  = rdEn && (addr == A_RXDATA);
    stb.clrRx  = wrEn && (addr == A_CTRL) && wdata[11];
    stb.clrTx  = wrEn && (addr == A_CTRL) && wdata[12];
    stb.clrErr = wrEn && (addr == A_CTRL) && wdata[13];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RXDATA: rdata[7:0] = st.rxEmpty ? 8'h00 : st.rxHead;
      A_CTRL:   rdata[10:0] = ctrlR;
      A_STAT: begin
        rdata[0] = st.rxEmpty;
        rdata[1] = st.txFull;
        rdata[2] = st.frameErr;
        rdata[3] = st.parErr;
        rdata[8 +: CNT_W]  = st.rxCount;
        rdata[16 +: CNT_W] = st.txCount;
      end
      A_THRESH: rdata[15:0] = threshR;
      A_BAUD: begin
        rdata[DIV_W-1:0] = divR; rdata[23] = useXtal; rdata[24] = useNew;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_datapath.sv
`timescale 1ns/1ps
module sp_datapath
  import sp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t stb,
  output status_t st,
  output logic    txd,
  input  logic    rxd,
  input  logic    cts,
  output logic    rts,
  output logic    irq
);
  logic [3:0] dataBits, hasPar;
  assign dataBits = 4'd5 + {2'b00, cfg.lenSel};
  assign hasPar   = {3'b000, (cfg.parSel == PAR_EVEN) || (cfg.parSel == PAR_ODD)};

  // ---------------- transmit ----------------
  logic [7:0]       txHead, txData;
  logic             txEmpty, txBusy, txStart;
  logic [FRM_W-1:0] txFrame, txFrameNext;
  logic [3:0]       txBits, txTotal;
  logic [BC_W-1:0]  txCnt;

  sp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) uTxFifo (
    .clk(clk), .rstN(rstN), .clr(stb.clrTx), .push(stb.pushTx), .pop(txStart),
    .din(stb.wrByte), .head(txHead), .count(st.txCount), .full(st.txFull), .empty(txEmpty));

  assign txStart = !txBusy && cfg.txEn && !txEmpty && (cfg.twoWire || cts);
  assign txData  = txHead & (8'hFF >> (4'd8 - dataBits));
  assign txTotal = 4'd2 + dataBits + hasPar + {3'b000, cfg.twoStop};

  always_comb begin
    txFrameNext    = '1;
    txFrameNext[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(dataBits)) txFrameNext[i+1] = txData[i];
    if (hasPar[0]) txFrameNext[dataBits + 4'd1] = (^txData) ^ (cfg.parSel == PAR_ODD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0; txFrame <= '1; txBits <= '0; txCnt <= '0;
    end else if (stb.clrTx) begin
      txBusy <= 1'b0; txFrame <= '1;
    end else if (txStart) begin
      txBusy <= 1'b1; txFrame <= txFrameNext;
      txBits <= txTotal - 4'd1; txCnt <= cfg.bitCycles - BC_W'(1);
    end else if (txBusy) begin
      if (txCnt != '0) txCnt <= txCnt - BC_W'(1);
      else if (txBits == '0) txBusy <= 1'b0;
      else begin
        txFrame <= {1'b1, txFrame[FRM_W-1:1]};
        txBits  <= txBits - 4'd1;
        txCnt   <= cfg.bitCycles - BC_W'(1);
      end
    end
  end

  assign txd = txBusy ? txFrame[0] : 1'b1;

  // ---------------- receive ----------------
  logic             rxMeta, rxS, rxPrev, rxBusy, rxSampleNow, rxDone;
  logic [3:0]       rxIdx, rxLast;
  logic [BC_W-1:0]  rxCnt;
  logic [FRM_W-1:0] rxSamp, rxSampNext;
  logic [7:0]       rxByte;
  logic             rxParOk, rxStopOk;

  assign rxLast      = dataBits + hasPar + 4'd1;
  assign rxSampleNow = rxBusy && (rxCnt == '0);
  assign rxDone      = rxSampleNow && (rxIdx == rxLast);

  always_comb begin
    rxSampNext        = rxSamp;
    rxSampNext[rxIdx] = rxS;
    for (int i = 0; i < 8; i++)
      rxByte[i] = (i < int'(dataBits)) ? rxSampNext[i+1] : 1'b0;
    rxParOk  = !hasPar[0] ||
               (rxSampNext[dataBits + 4'd1] == ((^rxByte) ^ (cfg.parSel == PAR_ODD)));
    rxStopOk = rxSampNext[dataBits + 4'd1 + hasPar];
  end

  sp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) uRxFifo (
    .clk(clk), .rstN(rstN), .clr(stb.clrRx), .push(rxDone), .pop(stb.popRx),
    .din(rxByte), .head(st.rxHead), .count(st.rxCount), .full(st.rxFull), .empty(st.rxEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1; rxS <= 1'b1; rxPrev <= 1'b1;
      rxBusy <= 1'b0; rxIdx <= '0; rxCnt <= '0; rxSamp <= '0;
      st.parErr <= 1'b0; st.frameErr <= 1'b0;
    end else begin
      rxMeta <= rxd; rxS <= rxMeta; rxPrev <= rxS;
      if (stb.clrRx) rxBusy <= 1'b0;
      else if (!rxBusy) begin
        if (cfg.rxEn && rxPrev && !rxS) begin
          rxBusy <= 1'b1; rxIdx <= '0; rxSamp <= '0; rxCnt <= cfg.bitCycles >> 1;
        end
      end else if (!rxSampleNow) rxCnt <= rxCnt - BC_W'(1);
      else if ((rxIdx == '0 && rxS) || rxDone) rxBusy <= 1'b0;
      else begin
        rxSamp <= rxSampNext; rxIdx <= rxIdx + 4'd1; rxCnt <= cfg.bitCycles - BC_W'(1);
      end
      if (stb.clrErr) begin
        st.parErr <= 1'b0; st.frameErr <= 1'b0;
      end else if (rxDone) begin
        st.parErr   <= st.parErr | !rxParOk;
        st.frameErr <= st.frameErr | !rxStopOk;
      end
    end
  end

  assign rts = !(cfg.rtsInv || (!cfg.twoWire && st.rxFull));
  assign irq = (cfg.txIrqEn && (8'(st.txCount) < cfg.txThresh)) ||
               (cfg.rxIrqEn && (8'(st.rxCount) >= cfg.rxThresh));

  // R8: flow control holds the transmitter idle while clear-to-send is low
  assert_cts_holds_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !cfg.twoWire && !cts) |=> !txBusy);
  // R11: a disabled transmitter never starts a character
  assert_tx_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !cfg.txEn) |=> !txBusy);
  // R4: a push into a full queue leaves the occupancy unchanged
  assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushTx && st.txFull && !txStart && !stb.clrTx) |=> (st.txCount == $past(st.txCount)));
  // R5: a pop from an empty queue leaves it empty
  assert_empty_read_no_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popRx && st.rxEmpty && !rxDone && !stb.clrRx) |=> (st.rxCount == '0));
  // R6: error flags stay set until explicitly cleared
  assert_par_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.parErr && !stb.clrErr) |=> st.parErr);
  assert_frame_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.frameErr && !stb.clrErr) |=> st.frameErr);
endmodule

// File: rtl/serial_port_ctrl.sv
`timescale 1ns/1ps
module serial_port_ctrl
  import sp_pkg::*;
#(
  parameter int DEF_DIV = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts,
  output logic        rts,
  output logic        irq
);
  cfg_t    cfg;
  strobe_t stb;
  status_t st;

  sp_ctrl #(.DEF_DIV(DEF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .st(st), .cfg(cfg), .stb(stb));

  sp_datapath uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .st(st),
    .txd(txd), .rxd(rxd), .cts(cts), .rts(rts), .irq(irq));
endmodule

// File: tb/sim_serial_port_ctrl.sv
`timescale 1ns/1ps
module sim_serial_port_ctrl;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rxd = 1'b1, cts = 1'b1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic txd, rts, irq;

  int compared = 0, mismatched = 0, bitCyc = 24, mLen = 8, mPar = 0, mStop = 1;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  serial_port_ctrl #(.DEF_DIV(7)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .txd(txd), .rxd(rxd), .cts(cts), .rts(rts), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // control word: len field, two stop, parity, two-wire, rts suppress, enables, irq enables
  function automatic logic [31:0] cw(input int lenSel, twoStop, par, twoWire, rtsInv,
                                     txEn, rxEn, txIe, rxIe);
    return 32'(lenSel) | (32'(twoStop) << 2) | (32'(par) << 3) | (32'(twoWire) << 5) |
           (32'(rtsInv) << 6) | (32'(txEn) << 7) | (32'(rxEn) << 8) |
           (32'(txIe) << 9) | (32'(rxIe) << 10);
  endfunction

  function automatic logic parOf(input logic [7:0] d, input int par);
    return (^d) ^ (par == 2);
  endfunction

  // driver: queue the expected character, then write it
  task automatic txByte(input logic [7:0] b);
    expQ.push_back(b & (8'hFF >> (8 - mLen)));
    wr(3'd0, 32'(b));
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    repeat (2 * bitCyc) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] b, input int par, input bit flipPar, input bit badStop);
    logic [7:0] m;
    m = b & (8'hFF >> (8 - mLen));
    @(negedge clk); rxd = 1'b0; repeat (bitCyc) @(negedge clk);
    for (int i = 0; i < mLen; i++) begin rxd = m[i]; repeat (bitCyc) @(negedge clk); end
    if (par != 0) begin rxd = parOf(m, par) ^ flipPar; repeat (bitCyc) @(negedge clk); end
    rxd = !badStop; repeat (bitCyc) @(negedge clk);
    rxd = 1'b1; repeat (bitCyc) @(negedge clk);
  endtask

  // monitor: decode every character on txd and compare with the scoreboard
  initial begin
    logic [7:0] d;
    logic pb;
    forever begin
      @(negedge txd);
      repeat (bitCyc / 2) @(negedge clk);
      chk("R2 start bit", 32'(txd), 32'd0);
      d = '0;
      for (int i = 0; i < mLen; i++) begin repeat (bitCyc) @(negedge clk); d[i] = txd; end
      if (mPar != 0) begin
        repeat (bitCyc) @(negedge clk); pb = txd;
        chk("R2 parity bit", 32'(pb), 32'(parOf(d, mPar)));
      end
      for (int s = 0; s < mStop; s++) begin
        repeat (bitCyc) @(negedge clk);
        chk("R2 stop bit", 32'(txd), 32'd1);
      end
      if (expQ.size() == 0) chk("R2 unexpected character", 32'(d), 32'hFFFF);
      else chk("R2 data", 32'(d), 32'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] r;
    int w;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 rts", 32'(rts), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(3'd3, r);
    chk("R1 status", r, 32'h1);

    // R2 formats at 12 cycles per bit
    wr(3'd5, (32'd1 << 24) | (32'd1 << 23) | 32'd3); bitCyc = 12;
    wr(3'd4, 32'h0102);
    wr(3'd2, cw(3,0,0,1,0,1,1,0,0)); mLen = 8; mPar = 0; mStop = 1;
    txByte(8'hA5); txByte(8'h3C); drain();
    wr(3'd2, cw(0,1,1,1,0,1,1,0,0)); mLen = 5; mPar = 1; mStop = 2;
    txByte(8'hF3); txByte(8'h0E); drain();
    wr(3'd2, cw(2,0,2,1,0,1,1,0,0)); mLen = 7; mPar = 2; mStop = 1;
    txByte(8'h7F); txByte(8'h80); drain();
    wr(3'd2, cw(3,0,0,1,0,1,1,0,0)); mLen = 8; mPar = 0; mStop = 1;

    // R3: baud source bits clear -> default divisor 7 -> 24 cycles
    wr(3'd5, 32'd3); bitCyc = 24;
    txByte(8'h00);
    @(negedge txd);
    w = 0; @(negedge clk);
    while (txd == 1'b0) begin w++; @(negedge clk); end
    chk("R3 default bit period (9 low bits)", 32'(w), 32'd216);
    drain();
    wr(3'd5, (32'd1 << 24) | (32'd1 << 23) | 32'd3); bitCyc = 12;
    txByte(8'h00);
    @(negedge txd);
    w = 0; @(negedge clk);
    while (txd == 1'b0) begin w++; @(negedge clk); end
    chk("R3 programmed bit period", 32'(w), 32'd108);
    drain();

    // R4 / R11: fill the transmit queue with the transmitter off
    wr(3'd2, cw(3,0,0,1,0,0,1,0,0));
    for (int i = 0; i < 65; i++) wr(3'd0, 32'(i));
    rd(3'd3, r);
    chk("R4 tx count at full", 32'(r[22:16]), 32'd64);
    chk("R4 txFull", 32'(r[1]), 32'd1);
    chk("R11 txd idle while disabled", 32'(txd), 32'd1);
    // R7: transmit reset
    wr(3'd2, cw(3,0,0,1,0,0,1,0,0) | (32'd1 << 12));
    rd(3'd3, r);
    chk("R7 tx queue emptied", 32'(r[22:16]), 32'd0);

    // R8: flow control waits for cts
    cts = 1'b0;
    wr(3'd2, cw(3,0,0,0,0,1,1,0,0));
    wr(3'd0, 32'h66);
    repeat (5 * bitCyc) @(negedge clk);
    chk("R8 held by cts", 32'(txd), 32'd1);
    rd(3'd3, r);
    chk("R8 byte still queued", 32'(r[22:16]), 32'd1);
    expQ.push_back(8'h66); cts = 1'b1; drain();
    cts = 1'b0;
    wr(3'd2, cw(3,0,0,1,0,1,1,0,0));
    txByte(8'h99); drain();
    chk("R8 two-wire ignores cts", 32'(expQ.size()), 32'd0);
    cts = 1'b1;

    // R5: receive and pop
    sendRx(8'h5A, 0, 0, 0);
    rd(3'd3, r);
    chk("R5 rx count", 32'(r[14:8]), 32'd1);
    rd(3'd1, r); chk("R5 rx data", r, 32'h5A);
    rd(3'd1, r); chk("R5 empty read returns 0", r, 32'h0);
    rd(3'd3, r); chk("R5 empty status", 32'(r[0]), 32'd1);

    // R6: parity and stop errors
    wr(3'd2, cw(3,0,1,1,0,0,1,0,0)); mPar = 1;
    sendRx(8'h33, 1, 1, 0);
    rd(3'd3, r); chk("R6 parity error", 32'(r[3:2]), 32'b10);
    rd(3'd3, r); chk("R6 parity error sticky", 32'(r[3]), 32'd1);
    sendRx(8'h44, 1, 0, 1);
    rd(3'd3, r); chk("R6 frame error", 32'(r[3:2]), 32'b11);
    wr(3'd2, cw(3,0,1,1,0,0,1,0,0) | (32'd1 << 13));
    rd(3'd3, r); chk("R6 errors cleared", 32'(r[3:2]), 32'b00);
    chk("R6 bytes kept", 32'(r[14:8]), 32'd2);
    wr(3'd2, cw(3,0,0,1,0,0,1,0,0) | (32'd1 << 11)); mPar = 0;
    rd(3'd3, r); chk("R7 rx queue emptied", 32'(r[14:8]), 32'd0);

    // R10: interrupt thresholds
    wr(3'd4, 32'h0202);
    wr(3'd2, cw(3,0,0,1,0,0,1,0,1));
    sendRx(8'h01, 0, 0, 0);
    chk("R10 rx below threshold", 32'(irq), 32'd0);
    sendRx(8'h02, 0, 0, 0);
    chk("R10 rx at threshold", 32'(irq), 32'd1);
    rd(3'd1, r);
    chk("R10 rx drops after pop", 32'(irq), 32'd0);
    wr(3'd2, cw(3,0,0,1,0,0,1,1,0) | (32'd1 << 11));
    chk("R10 tx below threshold", 32'(irq), 32'd1);
    wr(3'd0, 32'h11); wr(3'd0, 32'h22);
    chk("R10 tx at threshold", 32'(irq), 32'd0);
    wr(3'd2, cw(3,0,0,1,0,0,1,0,0) | (32'd1 << 12));
    chk("R10 disabled", 32'(irq), 32'd0);

    // R11: receiver disabled
    wr(3'd2, cw(3,0,0,1,0,0,0,0,0));
    sendRx(8'h77, 0, 0, 0);
    rd(3'd3, r); chk("R11 rx disabled", 32'(r[14:8]), 32'd0);

    // R9: rts
    wr(3'd2, cw(3,0,0,1,1,0,1,0,0));
    chk("R9 rts suppressed", 32'(rts), 32'd0);
    wr(3'd2, cw(3,0,0,0,0,0,1,0,0));
    chk("R9 rts ready", 32'(rts), 32'd1);
    for (int i = 0; i < 64; i++) sendRx(8'(i), 0, 0, 0);
    chk("R9 rts low at rx full", 32'(rts), 32'd0);
    rd(3'd1, r);
    chk("R5 oldest byte first", r, 32'h0);
    chk("R9 rts back after pop", 32'(rts), 32'd1);
    sendRx(8'hEE, 0, 0, 0);
    chk("R9 full again", 32'(rts), 32'd0);
    wr(3'd2, cw(3,0,0,1,0,0,1,0,0));
    chk("R9 two-wire keeps rts high", 32'(rts), 32'd1);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule